// File: doc/BRIEF.md
# Processor Interrupt Pin Conditioner

This block sits between the already-synchronized control pins of a processor and the core itself. Each pin sample arrives as an update event: a pin index and a new level. The block keeps the last level seen on every pin and reacts only when a sample differs from that stored level. Repeated equal samples produce no event.

Pins follow different rules, depending on their type. Three pins are active-high levels whose value is copied into a pending-interrupt bit: external, system-management and soft-reset. The machine-check pin sets a sticky pending bit on a 1-to-0 transition only. The time-base enable pin starts and freezes the time base. Two active-low pins act on the core: a checkstop pin halts the core until the next reset, and a hard-reset pin emits a one-cycle reset request. Software clears pending bits with a masked acknowledge strobe. A combined request line is high while any pending bit is set.

Pin updates are plain control strobes with no back-pressure: an update is taken on every cycle in which `upd_valid` is high, and the same holds for acknowledges.

Top module: `pinc_top`

## Requirements
- R1: A pin update whose level equals the stored level of that pin has no effect on any output. Each valid update to a defined pin replaces its stored level. All stored levels are 0 after reset.
- R2: External pin (index 1) is active high: a change to 1 sets pending bit 0, and a change to 0 clears it.
- R3: System-management pin (index 2) is active high: a change to 1 sets pending bit 1, and a change to 0 clears it.
- R4: Time-base pin (index 0): a change to 0 drives `tb_en` low, and a change to 1 drives it high. `tb_en` is 1 after reset.
- R5: Machine-check pin (index 3): a 1-to-0 change sets pending bit 2. No pin activity clears that bit.
- R6: Checkstop pin (index 4) is active low: a change to 0 raises `core_stop`, which stays high until reset.
- R7: Hard-reset pin (index 5) is active low: a change to 0 produces `rst_req` high for exactly the following cycle.
- R8: Soft-reset pin (index 6): a change to 1 sets pending bit 3, and a change to 0 clears it.
- R9: `irq_req` is high exactly while the pending vector is non-zero.
- R10: An update with a pin index of 7 or above changes no output and no stored level.
- R11: An acknowledge with `ack_valid` high clears the pending bits selected by `ack_mask`. A set from a pin in the same cycle wins over the clear.
- R12: Reset clears the pending vector, `core_stop` and `rst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Pin update strobe |
| upd_pin | input | IDX_W (4) | Index of the updated pin |
| upd_level | input | 1 | New sampled level of that pin |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_mask | input | 4 | Pending bits to clear |
| pend | output | 4 | Pending vector: bit 0 external, bit 1 system-management, bit 2 machine check, bit 3 soft reset |
| irq_req | output | 1 | Any pending bit set |
| tb_en | output | 1 | Time-base run enable |
| core_stop | output | 1 | Core halted by checkstop |
| rst_req | output | 1 | One-cycle hard-reset request |

## Verification
The bench builds the block with the default IDX_W of 4. This leaves indices 7 to 15 free, so undefined-pin updates can be mixed with real ones, and the bench can check that they leave both outputs and stored levels untouched. The random phase draws indices from 0 to 9 with random acknowledges. This reaches same-cycle set/clear collisions and repeated equal samples on every pin type.

// File: rtl/pinc_pkg.sv
package pinc_pkg;
  localparam int NUM_PINS = 7;
  localparam int PIN_TB   = 0;
  localparam int PIN_EXT  = 1;
  localparam int PIN_SMI  = 2;
  localparam int PIN_MCHK = 3;
  localparam int PIN_CSTP = 4;
  localparam int PIN_HRST = 5;
  localparam int PIN_SRST = 6;

  localparam int PEND_W   = 4;
  localparam int PB_EXT   = 0;
  localparam int PB_SMI   = 1;
  localparam int PB_MCHK  = 2;
  localparam int PB_SRST  = 3;

  typedef logic [NUM_PINS-1:0] pin_vec_t;
  typedef logic [PEND_W-1:0]   pend_vec_t;
endpackage

// File: rtl/pinc_filter.sv
module pinc_filter
  import pinc_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_pin,
  input  logic             upd_level,
  output pin_vec_t         rise,
  output pin_vec_t         fall,
  output pin_vec_t         lvl_q
);
  pin_vec_t chg;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic hit;
    assign hit     = upd_valid && (upd_pin == IDX_W'(g));
    assign chg[g]  = hit && (upd_level != lvl_q[g]);
    assign rise[g] = chg[g] && upd_level;
    assign fall[g] = chg[g] && !upd_level;

    always_ff @(posedge clk) begin
      if (!rst_n)      lvl_q[g] <= 1'b0;
      else if (chg[g]) lvl_q[g] <= upd_level;
    end
  end

  // R10: out-of-range index leaves stored levels untouched
  p_undef_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (32'(upd_pin) >= NUM_PINS)) |=> $stable(lvl_q));

  // R1: at most one pin changes per update
  p_single_change_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rise | fall));
endmodule

// File: rtl/pinc_pending.sv
module pinc_pending
  import pinc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pin_vec_t  rise,
  input  pin_vec_t  fall,
  input  logic      ack_valid,
  input  pend_vec_t ack_mask,
  output pend_vec_t pend_q
);
  pend_vec_t set_v, clr_v, ack_v, nxt;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[PB_EXT]  = rise[PIN_EXT];
    clr_v[PB_EXT]  = fall[PIN_EXT];
    set_v[PB_SMI]  = rise[PIN_SMI];
    clr_v[PB_SMI]  = fall[PIN_SMI];
    set_v[PB_SRST] = rise[PIN_SRST];
    clr_v[PB_SRST] = fall[PIN_SRST];
    set_v[PB_MCHK] = fall[PIN_MCHK];
    ack_v = ack_valid ? ack_mask : '0;
    nxt   = (pend_q & ~clr_v & ~ack_v) | set_v;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= nxt;
  end

  // R11: a same-cycle set survives an acknowledge
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rise[PIN_EXT] |=> pend_q[PB_EXT]);

  // R5: machine-check bit only leaves through acknowledge
  p_mchk_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[PB_MCHK] && !(ack_valid && ack_mask[PB_MCHK])) |=> pend_q[PB_MCHK]);

  // R9: an empty vector stays empty without a pin set
  p_idle_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q == '0) && (rise == '0) && !fall[PIN_MCHK]) |=> (pend_q == '0));
endmodule

// File: rtl/pinc_core.sv
module pinc_core
  import pinc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pin_vec_t rise,
  input  pin_vec_t fall,
  output logic     tb_en_q,
  output logic     stop_q,
  output logic     rreq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tb_en_q <= 1'b1;
      stop_q  <= 1'b0;
      rreq_q  <= 1'b0;
    end else begin
      if (rise[PIN_TB])      tb_en_q <= 1'b1;
      else if (fall[PIN_TB]) tb_en_q <= 1'b0;
      if (fall[PIN_CSTP])    stop_q  <= 1'b1;
      rreq_q <= fall[PIN_HRST];
    end
  end

  p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> stop_q);

  p_rst_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_q |=> !rreq_q);

  p_tb_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise[PIN_TB] |=> tb_en_q);
endmodule

// File: rtl/pinc_top.sv
module pinc_top
  import pinc_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_pin,
  input  logic             upd_level,
  input  logic             ack_valid,
  input  logic [3:0]       ack_mask,
  output logic [3:0]       pend,
  output logic             irq_req,
  output logic             tb_en,
  output logic             core_stop,
  output logic             rst_req
);
  pin_vec_t  rise, fall, lvl_q;
  pend_vec_t pend_q;

  pinc_filter #(.IDX_W(IDX_W)) u_filter (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_pin(upd_pin),
    .upd_level(upd_level), .rise(rise), .fall(fall), .lvl_q(lvl_q)
  );

  pinc_pending u_pend (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .ack_valid(ack_valid), .ack_mask(ack_mask), .pend_q(pend_q)
  );

  pinc_core u_core (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .tb_en_q(tb_en), .stop_q(core_stop), .rreq_q(rst_req)
  );

  assign pend    = pend_q;
  assign irq_req = |pend_q;

  // R12: reset state seen one cycle after a reset cycle
  p_reset_state_r12: assert property (@(posedge clk)
    $past(!rst_n) |-> (pend == '0 && !core_stop && !rst_req && tb_en));

  // R9: request line drops only when the vector has emptied
  p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_req) |-> (pend == '0));
endmodule

// File: tb/pinc_top_bench.sv
`timescale 1ns/1ps
module pinc_top_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic upd_valid, upd_level, ack_valid;
  logic [3:0] upd_pin, ack_mask;
  logic [3:0] pend;
  logic irq_req, tb_en, core_stop, rst_req;

  int n_tests = 0;
  int n_fail  = 0;

  bit [6:0] m_lvl;
  bit [3:0] m_pend;
  bit       m_tb, m_stop, m_rreq;

  always #5 clk = ~clk;

  pinc_top u_pinc_top (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_pin(upd_pin),
    .upd_level(upd_level), .ack_valid(ack_valid), .ack_mask(ack_mask),
    .pend(pend), .irq_req(irq_req), .tb_en(tb_en), .core_stop(core_stop),
    .rst_req(rst_req)
  );

  function automatic bit [3:0] next_pend(bit [3:0] p, bit chg, int idx, bit lv,
                                         bit av, bit [3:0] mk);
    bit [3:0] s = '0, c = '0;
    if (chg) begin
      case (idx)
        1: if (lv) s[0] = 1; else c[0] = 1;
        2: if (lv) s[1] = 1; else c[1] = 1;
        3: if (!lv) s[2] = 1;
        6: if (lv) s[3] = 1; else c[3] = 1;
        default: ;
      endcase
    end
    if (av) c = c | mk;
    return (p & ~c) | s;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(pend == m_pend, {tag, " pend"}, pend, m_pend);
    chk(irq_req == (m_pend != 0), {tag, " R9 irq_req"}, irq_req, m_pend != 0);
    chk(tb_en == m_tb, {tag, " tb_en"}, tb_en, m_tb);
    chk(core_stop == m_stop, {tag, " core_stop"}, core_stop, m_stop);
    chk(rst_req == m_rreq, {tag, " rst_req"}, rst_req, m_rreq);
  endtask

  task automatic step(bit v, int idx, bit lv, bit av, bit [3:0] mk, string tag);
    bit chg;
    @(negedge clk);
    upd_valid = v; upd_pin = 4'(idx); upd_level = lv;
    ack_valid = av; ack_mask = mk;
    chg = v && idx < 7 && (m_lvl[idx] != lv);
    m_pend = next_pend(m_pend, chg, idx, lv, av, mk);
    m_rreq = chg && idx == 5 && !lv;
    if (chg && idx == 0) m_tb = lv;
    if (chg && idx == 4 && !lv) m_stop = 1;
    if (chg) m_lvl[idx] = lv;
    @(posedge clk); #1;
    compare(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; upd_valid = 0; ack_valid = 0; upd_pin = 0; upd_level = 0; ack_mask = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    m_lvl = '0; m_pend = '0; m_tb = 1; m_stop = 0; m_rreq = 0;
    #1;
    compare("R12 reset");
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    do_reset();
    // R2 external level copy; R1 repeat equal sample after ack gives no re-set
    step(1, 1, 1, 0, 0, "R2 ext up");
    step(1, 1, 1, 1, 4'b0001, "R11 ack vs equal sample");
    step(1, 1, 1, 0, 0, "R1 repeat equal");
    step(1, 1, 0, 0, 0, "R2 ext down");
    // R3
    step(1, 2, 1, 0, 0, "R3 smi up");
    step(1, 2, 0, 0, 0, "R3 smi down");
    // R4
    step(1, 0, 0, 0, 0, "R4 tb equal at reset");
    step(1, 0, 1, 0, 0, "R4 tb rise");
    step(1, 0, 0, 0, 0, "R4 tb freeze");
    step(1, 0, 1, 0, 0, "R4 tb restart");
    // R5
    step(1, 3, 1, 0, 0, "R5 mchk rise no set");
    step(1, 3, 0, 0, 0, "R5 mchk fall sets");
    step(1, 3, 1, 0, 0, "R5 mchk stays");
    step(1, 3, 0, 1, 4'b0100, "R11 set wins over ack");
    step(0, 0, 0, 1, 4'b0100, "R11 ack clears");
    // R8
    step(1, 6, 1, 0, 0, "R8 srst up");
    step(1, 6, 0, 0, 0, "R8 srst down");
    // R10
    step(1, 9, 1, 0, 0, "R10 undefined idx");
    step(1, 15, 0, 0, 0, "R10 undefined idx");
    // R7
    step(1, 5, 0, 0, 0, "R7 hrst equal no pulse");
    step(1, 5, 1, 0, 0, "R7 hrst release");
    step(1, 5, 0, 0, 0, "R7 hrst pulse");
    step(0, 0, 0, 0, 0, "R7 pulse ends");
    // R6
    step(1, 4, 1, 0, 0, "R6 cstp high");
    step(1, 4, 0, 0, 0, "R6 cstp stop");
    step(1, 4, 1, 0, 0, "R6 stop held");
    do_reset();
    for (int i = 0; i < 600; i++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 9), 1'($urandom),
           $urandom_range(0, 3) == 0, 4'($urandom),
           "R1 R2 R3 R5 R8 R10 R11 random");
      if (i == 300) do_reset();
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule